// File: doc/BRIEF.md
# Serial-In Latched Output Driver

This block is the logic of a cascadable serial-to-parallel driver. Bits arrive one at a time on `ser_in` and are clocked into a shift register of `STAGES` positions on each rising edge of `clk`. Stage 1 takes the new bit, and every other stage takes the content of the stage before it. The last stage appears on `ser_out`, so several instances can be chained into one longer register.

A bank of level-sensitive latches sits behind the shift register. While `latch_open` is high the latches are transparent. While it is low they keep their contents, and shifting goes on underneath without reaching the outputs.

Each output `drv_on[i]` is the complement of latch bit `i`, with 1 meaning the driver sinks current. The active-high `blank` input turns every driver off. An asynchronous active-low `rst_n` clears the shift stages and the latches. In use, `blank` stays high until valid data has been shifted in and latched.

Top module: `sipo_latched_driver`

## Requirements
- R1: On each rising edge of `clk`, stage 1 (`drv_on[0]` side) captures `ser_in`, and stage k+1 captures the previous content of stage k.
- R2: `ser_out` equals the last shift stage and changes only after a rising edge of `clk`.
- R3: While `latch_open` is 1, each latch bit follows its shift stage, so the outputs track the shift register as it shifts.
- R4: While `latch_open` is 0, the latch contents do not change, whatever is shifted.
- R5: With `blank` at 0, `drv_on[i]` is the inverse of latch bit `i` (1 = driver sinking, 0 = off).
- R6: With `blank` at 1, every bit of `drv_on` is 0 regardless of the latch contents.
- R7: When `ser_out` of one instance feeds `ser_in` of the next, M instances behave as a single register of STAGES×M stages.
- R8: While `rst_n` is 0, all shift stages and latch bits are 0, so `ser_out` is 0 and `drv_on` is all ones unless `blank` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low clear of shift stages and latches |
| ser_in | input | 1 | Serial data into stage 1 |
| latch_open | input | 1 | 1 = latches transparent, 0 = latches hold |
| blank | input | 1 | 1 = all drivers forced off |
| ser_out | output | 1 | Last shift stage, for chaining |
| drv_on | output | STAGES | Driver-on outputs, bit 0 is stage 1 |

## Verification
The bench chains two instances and targets a closed latch during continued shifting. A latch that leaks would change the outputs in the middle of a hold. It also targets `blank` asserted over a mix of latch contents, where a wrong gate would leave some drivers sinking. A single 1 walked through all sixteen stages exposes swapped shift direction, a missing inversion and an off-by-one `ser_out` tap, because each would place the driven bit at the wrong position or polarity. The downstream instance shows whether `ser_out` changes early enough to race the next register.

// File: rtl/sipo_drv_pkg.sv
package sipo_drv_pkg;
  localparam int MIN_STAGES = 2;

  // drive level of one output: latched 0 turns driver on, blank forces off
  function automatic logic drive_level(input logic held_bit, input logic blank_in);
    return (!blank_in) && (!held_bit);
  endfunction
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  output logic [STAGES-1:0] stage_q,
  output logic              tail
);
  localparam int LAST = STAGES - 1;

  function automatic logic [STAGES-1:0] advance(input logic [STAGES-1:0] cur, input logic bit_in);
    return {cur[LAST-1:0], bit_in};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= advance(stage_q, din);
  end

  assign tail = stage_q[LAST];
endmodule

// File: rtl/sipo_latch_bank.sv
module sipo_latch_bank #(
  parameter int STAGES = 8
) (
  input  logic              rst_n,
  input  logic              open_in,
  input  logic [STAGES-1:0] d,
  output logic [STAGES-1:0] q
);
  always_latch begin
    if (!rst_n)       q = '0;
    else if (open_in) q = d;
  end
endmodule

// File: rtl/sipo_out_stage.sv
module sipo_out_stage #(
  parameter int STAGES = 8
) (
  input  logic              blank_in,
  input  logic [STAGES-1:0] held,
  output logic [STAGES-1:0] drv
);
  import sipo_drv_pkg::*;

  for (genvar i = 0; i < STAGES; i++) begin : g_bit
    assign drv[i] = drive_level(held[i], blank_in);
  end
endmodule

// File: rtl/sipo_latched_driver.sv
module sipo_latched_driver #(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              latch_open,
  input  logic              blank,
  output logic              ser_out,
  output logic [STAGES-1:0] drv_on
);
  import sipo_drv_pkg::*;

  // named internal wires, observed by the bound checker
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] latch_q;

  initial begin
    if (STAGES < MIN_STAGES) $error("STAGES must be at least %0d", MIN_STAGES);
  end

  sipo_shift_chain #(.STAGES(STAGES)) u_shift (
    .clk(clk), .rst_n(rst_n), .din(ser_in), .stage_q(stage_q), .tail(ser_out)
  );

  sipo_latch_bank #(.STAGES(STAGES)) u_latch (
    .rst_n(rst_n), .open_in(latch_open), .d(stage_q), .q(latch_q)
  );

  sipo_out_stage #(.STAGES(STAGES)) u_out (
    .blank_in(blank), .held(latch_q), .drv(drv_on)
  );
endmodule

// File: rtl/sipo_latched_driver_chk.sv
module sipo_latched_driver_chk #(
  parameter int STAGES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_in,
  input logic              latch_open,
  input logic              blank,
  input logic              ser_out,
  input logic [STAGES-1:0] drv_on,
  input logic [STAGES-1:0] stage_q,
  input logic [STAGES-1:0] latch_q
);
  // R1: stage 1 holds the bit presented at the previous edge
  assert_stage1_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stage_q[0] == $past(ser_in));

  // R2: serial output is the old second-to-last stage, one edge later
  assert_tail_tap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_out == $past(stage_q[STAGES-2]));

  // R3: open latch and no blanking make outputs track the shift register
  assert_transparent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_open && !blank) |-> (drv_on == ~stage_q));

  // R4: closed over a whole cycle, the latch contents stay put
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_open && $past(!latch_open)) |-> $stable(latch_q));

  // R5: unblanked outputs are the complement of the latches
  assert_invert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !blank |-> (drv_on == ~latch_q));

  // R6: blanking drives every output off
  assert_blank_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (drv_on == '0));
endmodule

bind sipo_latched_driver sipo_latched_driver_chk #(.STAGES(STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .latch_open(latch_open), .blank(blank),
  .ser_out(ser_out), .drv_on(drv_on), .stage_q(stage_q), .latch_q(latch_q)
);

// File: tb/sipo_latched_driver_test.sv
`timescale 1ns/100ps
module sipo_latched_driver_test;
  localparam int N = 8;
  localparam int W = 2 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b0, latch_open = 1'b1, blank = 1'b1;
  logic link, tail;
  logic [N-1:0] drv_a, drv_b;

  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] ref_sr = '0, ref_lat = '0;
  logic [W-1:0] drv_seen;

  always #2.5 clk = ~clk;

  sipo_latched_driver #(.STAGES(N)) uut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .latch_open(latch_open), .blank(blank),
    .ser_out(link), .drv_on(drv_a)
  );
  sipo_latched_driver #(.STAGES(N)) uut_next (
    .clk(clk), .rst_n(rst_n), .ser_in(link), .latch_open(latch_open), .blank(blank),
    .ser_out(tail), .drv_on(drv_b)
  );

  function automatic logic [W-1:0] exp_drv(input logic [W-1:0] lat, input logic blk);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = blk ? 1'b0 : ~lat[i];
    return r;
  endfunction

  task automatic cmp(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    string tag;
    drv_seen = {drv_b, drv_a};
    tag = blank ? "R6" : (latch_open ? "R3/R5" : "R4/R5");
    cmp(tag, drv_seen, exp_drv(ref_lat, blank));
    cmp("R2", {15'd0, link}, {15'd0, ref_sr[N-1]});
    cmp("R7", {15'd0, tail}, {15'd0, ref_sr[W-1]});
  endtask

  // one cycle: drive at negedge, check, then model the edge and check again
  task automatic step(input logic sin, input logic lat, input logic blk);
    @(negedge clk);
    ser_in = sin; latch_open = lat; blank = blk;
    #1;
    if (lat) ref_lat = ref_sr;
    check_all();
    @(posedge clk);
    #1;
    ref_sr = {ref_sr[W-2:0], sin};   // R1 shift, R7 chained as one register
    if (lat) ref_lat = ref_sr;
    check_all();
  endtask

  initial begin : watchdog
    #(5 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    logic [W-1:0] hold_snap;
    void'($urandom(32'h5eed_1234));
    // R8: reset state
    #7;
    blank = 1'b0;
    #1;
    cmp("R8", {drv_b, drv_a}, {W{1'b1}});
    cmp("R8", {15'd0, link}, 16'd0);
    blank = 1'b1;
    #1;
    cmp("R6", {drv_b, drv_a}, '0);
    @(negedge clk); rst_n = 1'b1;

    // R1/R5/R7: walk a single one across both instances, latch open
    step(1'b1, 1'b1, 1'b0);
    for (int k = 0; k < W; k++) step(1'b0, 1'b1, 1'b0);

    // R4: fill pattern, close latch, keep shifting, outputs must not move
    for (int k = 0; k < W; k++) step(k[0] ^ k[2], 1'b1, 1'b0);
    hold_snap = {drv_b, drv_a};
    for (int k = 0; k < 10; k++) step(1'b1, 1'b0, 1'b0);
    cmp("R4", {drv_b, drv_a}, hold_snap);

    // R6: blank over held data, then unblank restores held value
    step(1'b0, 1'b0, 1'b1);
    cmp("R6", {drv_b, drv_a}, '0);
    step(1'b0, 1'b0, 1'b0);
    cmp("R5", {drv_b, drv_a}, hold_snap);

    // R3: reopen, latches catch up with shifted data
    step(1'b1, 1'b1, 1'b0);

    // random traffic with arbitrary latch and blank toggles
    for (int k = 0; k < 3000; k++)
      step(1'($urandom), ($urandom % 4) != 0, ($urandom % 5) == 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule